// File: doc/BRIEF.md
# Scan-Ready Cascaded Clock Divider

This block divides a functional clock by a fixed even prescale ratio and then by a power of two. The first section runs on the functional clock pin. The second section is a binary counter that is clocked by the divided clock from the first section, and its asynchronous clear comes from an internal reset synchroniser. Both sections stay on one serial test chain. A single test-mode input moves the second section's clock onto a dedicated scan clock pin and moves its clear onto the reset pin. When the fallback select is also set, the second section is instead held cleared for the whole of test mode and is left out of the serial path.

Latches sit in the serial path on both sides of the rerouted section. Each one is open only while the clock that launches its data is low. Because of this, a bit that crosses between the functional-clock flops and the scan-clock flops is held for half a cycle, and no bit is lost or duplicated when the two clocks arrive with some skew. When test mode is off, the divided output behaves exactly as a plain divider.

Top module: `scan_ready_clkdiv`

## Requirements
- R1: With `scan_mode_i` low, `clk_div_o` is periodic with a period of `PRE_DIV * 2**POST_BITS` rising edges of `clk_fn_i` (16 with the defaults) and stays high for half of that period.
- R2: With `scan_enable_i` high and both clocks pulsed together, the serial path has `RST_SYNC_DEPTH + CNT_W + 1 + POST_BITS` stages (6 with the defaults). A bit driven on `scan_in_i` before pulse k shows on `scan_out_o` in the low phase after pulse k+5.
- R3: `scan_out_o` changes only while the clock that launches it is low. Through the high phase of a shift pulse it keeps the value it had in the low phase before that pulse.
- R4: With `scan_mode_i` high, the second section advances only on rising edges of `clk_scan_i`. Pulses on `clk_fn_i` alone leave `clk_div_o` unchanged.
- R5: With `scan_mode_i` high, a low `rst_pin_ni` clears the second section. Once `rst_pin_ni` is released, the second section counts on the next `clk_scan_i` edge without any `clk_fn_i` edge. With `scan_enable_i` low it counts up by one per edge, and `clk_div_o` is its top bit, so `clk_div_o` rises on the `2**(POST_BITS-1)`-th pulse.
- R6: With `scan_mode_i` and `hold_sel_i` both high, `clk_div_o` stays 0 through any scan clock pulses, and the serial path shrinks by `POST_BITS` stages (to 4 with the defaults).
- R7: With `scan_mode_i` low, pulses on `clk_scan_i` have no effect on `clk_div_o` or `scan_out_o`, whatever the level of `scan_enable_i`.
- R8: With `scan_mode_i` low, `hold_sel_i` has no effect: the period and high time of R1 still hold.
- R9: While `rst_pin_ni` is low and both clocks are low, `clk_div_o` and `scan_out_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fn_i | input | 1 | Functional clock pin |
| clk_scan_i | input | 1 | Scan clock pin, used by the second section in test mode |
| rst_pin_ni | input | 1 | Active-low asynchronous reset pin |
| scan_mode_i | input | 1 | Test mode: moves the second section's clock and clear onto pins |
| scan_enable_i | input | 1 | Selects serial shift instead of the functional next state |
| scan_in_i | input | 1 | Serial test data in |
| hold_sel_i | input | 1 | In test mode, holds the second section cleared and bypasses it |
| scan_out_o | output | 1 | Serial test data out, after the trailing lockup latch |
| clk_div_o | output | 1 | Divided clock |

## Verification
The divided clock is taken from the second section's top bit. Both the first-section toggle and that bit change at a `clk_fn_i` rising edge, so every output is read 1 time unit into the low phase that follows the edge.

Serial data comes out zero cycles after the last flop's edge, because the trailing latch opens in that same low phase. The bench therefore expects a bit driven before pulse k to appear in the low phase after pulse k+L-1, where L is the chain length.

For R3, a second sample is taken 1 time unit into each high phase and compared with the sample from the low phase just before it. Counting and reset checks read `clk_div_o` after each single pulse, because the clear and count paths hold no extra register stage.

// File: rtl/scan_clkdiv_pkg.sv
package scan_clkdiv_pkg;

    localparam int unsigned RST_SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ROUTE_FUNC = 2'd0,
        ROUTE_SCAN = 2'd1,
        ROUTE_HOLD = 2'd2
    } route_e;

endpackage

// File: rtl/sdiv_prescale.sv
module sdiv_prescale #(
    parameter int unsigned PRE_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic shift_en_i,
    input  logic scan_si_i,
    output logic tog_o,
    output logic rst_int_no,
    output logic scan_so_o
);
    import scan_clkdiv_pkg::*;

    localparam int unsigned HALF  = PRE_DIV / 2;
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned SYNC  = RST_SYNC_DEPTH;
    localparam int unsigned CHAIN = SYNC + CNT_W + 1;

    typedef struct packed {
        logic [SYNC-1:0]  rsync;
        logic [CNT_W-1:0] cnt;
        logic             tog;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        logic [CHAIN:0]  shifted;
        logic [SYNC:0]   sync_ext;
        st_d     = st_q;
        shifted  = {st_q.tog, st_q.cnt, st_q.rsync, scan_si_i};
        sync_ext = {st_q.rsync, 1'b1};
        if (shift_en_i) begin
            {st_d.tog, st_d.cnt, st_d.rsync} = shifted[CHAIN-1:0];
        end else begin
            st_d.rsync = sync_ext[SYNC-1:0];
            if ({1'b0, st_q.cnt} >= (CNT_W+1)'(HALF - 1)) begin
                st_d.cnt = '0;
                st_d.tog = ~st_q.tog;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog_o      = st_q.tog;
    assign rst_int_no = st_q.rsync[SYNC-1];
    assign scan_so_o  = st_q.tog;

    AST_TOGGLE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_en_i && ({1'b0, st_q.cnt} == (CNT_W+1)'(HALF - 1))) |=> (st_q.tog != $past(st_q.tog))) // R1
        else $error("toggle missed at prescale wrap");

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_en_i |=> ({1'b0, st_q.cnt} < (CNT_W+1)'(HALF))) // R1
        else $error("prescale count out of range");

    AST_SHIFT_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_en_i |=> (st_q.cnt[0] == $past(st_q.rsync[SYNC-1]))) // R2
        else $error("serial link broken between sync and count");

endmodule

// File: rtl/sdiv_test_mux.sv
module sdiv_test_mux (
    input  logic                          scan_mode_i,
    input  logic                          hold_sel_i,
    input  logic                          clk_fn_i,
    input  logic                          clk_derived_i,
    input  logic                          clk_scan_i,
    input  logic                          rst_int_ni,
    input  logic                          rst_pin_ni,
    output logic                          clk_o,
    output logic                          rst_no,
    output logic                          tail_gate_o,
    output scan_clkdiv_pkg::route_e       route_o
);
    import scan_clkdiv_pkg::*;

    route_e route;

    always_comb begin
        if (!scan_mode_i) begin
            route = ROUTE_FUNC;
        end else if (hold_sel_i) begin
            route = ROUTE_HOLD;
        end else begin
            route = ROUTE_SCAN;
        end
    end

    always_comb begin
        unique case (route)
            ROUTE_FUNC: begin
                clk_o  = clk_derived_i;
                rst_no = rst_int_ni;
            end
            ROUTE_SCAN: begin
                clk_o  = clk_scan_i;
                rst_no = rst_pin_ni;
            end
            default: begin
                clk_o  = clk_scan_i;
                rst_no = 1'b0;
            end
        endcase
        tail_gate_o = (route == ROUTE_HOLD) ? clk_fn_i : clk_o;
    end

    assign route_o = route;

endmodule

// File: rtl/sdiv_lockup.sv
module sdiv_lockup (
    input  logic launch_clk_i,
    input  logic d_i,
    output logic q_o
);
    always_latch begin
        if (!launch_clk_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/sdiv_post.sv
module sdiv_post #(
    parameter int unsigned POST_BITS = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 shift_en_i,
    input  logic                 scan_si_i,
    output logic [POST_BITS-1:0] cnt_o
);
    logic [POST_BITS-1:0] cnt_d, cnt_q;

    always_comb begin
        logic [POST_BITS:0] shifted;
        shifted = {cnt_q, scan_si_i};
        if (shift_en_i) begin
            cnt_d = shifted[POST_BITS-1:0];
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/scan_ready_clkdiv.sv
module scan_ready_clkdiv #(
    parameter int unsigned PRE_DIV   = 4,
    parameter int unsigned POST_BITS = 2
) (
    input  logic clk_fn_i,
    input  logic clk_scan_i,
    input  logic rst_pin_ni,
    input  logic scan_mode_i,
    input  logic scan_enable_i,
    input  logic scan_in_i,
    input  logic hold_sel_i,
    output logic scan_out_o,
    output logic clk_div_o
);
    import scan_clkdiv_pkg::*;

    logic                 tog;
    logic                 rst_int_n;
    logic                 pre_so;
    logic                 clk_post;
    logic                 rst_post_n;
    logic                 tail_gate;
    route_e               route;
    logic                 head_latch_q;
    logic [POST_BITS-1:0] post_cnt;
    logic                 tail_d;

    sdiv_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk_i      (clk_fn_i),
        .rst_ni     (rst_pin_ni),
        .shift_en_i (scan_enable_i),
        .scan_si_i  (scan_in_i),
        .tog_o      (tog),
        .rst_int_no (rst_int_n),
        .scan_so_o  (pre_so)
    );

    sdiv_test_mux u_mux (
        .scan_mode_i   (scan_mode_i),
        .hold_sel_i    (hold_sel_i),
        .clk_fn_i      (clk_fn_i),
        .clk_derived_i (tog),
        .clk_scan_i    (clk_scan_i),
        .rst_int_ni    (rst_int_n),
        .rst_pin_ni    (rst_pin_ni),
        .clk_o         (clk_post),
        .rst_no        (rst_post_n),
        .tail_gate_o   (tail_gate),
        .route_o       (route)
    );

    sdiv_lockup u_head_lock (
        .launch_clk_i (clk_fn_i),
        .d_i          (pre_so),
        .q_o          (head_latch_q)
    );

    sdiv_post #(.POST_BITS(POST_BITS)) u_post (
        .clk_i      (clk_post),
        .rst_ni     (rst_post_n),
        .shift_en_i (scan_enable_i),
        .scan_si_i  (head_latch_q),
        .cnt_o      (post_cnt)
    );

    assign tail_d = (route == ROUTE_HOLD) ? head_latch_q : post_cnt[POST_BITS-1];

    sdiv_lockup u_tail_lock (
        .launch_clk_i (tail_gate),
        .d_i          (tail_d),
        .q_o          (scan_out_o)
    );

    assign clk_div_o = post_cnt[POST_BITS-1];

    AST_FALLBACK_HELD: assert property (@(posedge clk_fn_i) disable iff (!rst_pin_ni)
        (scan_mode_i && hold_sel_i) |-> (post_cnt == '0)) // R6
        else $error("fallback did not hold second section cleared");

endmodule

// File: tb/scan_ready_clkdiv_tb.sv
module scan_ready_clkdiv_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = CLK_PERIOD / 2;
    localparam int PRE_DIV    = 4;
    localparam int POST_BITS  = 2;
    localparam int HALF       = PRE_DIV / 2;
    localparam int CNT_W      = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int TOTAL      = PRE_DIV * (1 << POST_BITS);
    localparam int CHAIN_LEN  = 2 + CNT_W + 1 + POST_BITS;
    localparam int HOLD_LEN   = CHAIN_LEN - POST_BITS;
    localparam int NPAT       = 6;
    localparam logic [15:0] PATS [NPAT] = '{
        16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001, 16'h1234, 16'hF00F
    };

    logic clk_fn = 1'b0;
    logic clk_scan = 1'b0;
    logic rst_pin_n = 1'b0;
    logic scan_mode = 1'b0;
    logic scan_enable = 1'b0;
    logic scan_in = 1'b0;
    logic hold_sel = 1'b0;
    logic scan_out;
    logic clk_div;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    scan_ready_clkdiv #(.PRE_DIV(PRE_DIV), .POST_BITS(POST_BITS)) u_dut (
        .clk_fn_i      (clk_fn),
        .clk_scan_i    (clk_scan),
        .rst_pin_ni    (rst_pin_n),
        .scan_mode_i   (scan_mode),
        .scan_enable_i (scan_enable),
        .scan_in_i     (scan_in),
        .hold_sel_i    (hold_sel),
        .scan_out_o    (scan_out),
        .clk_div_o     (clk_div)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic f, input logic s);
        #HP;
        clk_fn = f;
        clk_scan = s;
        #HP;
        clk_fn = 1'b0;
        clk_scan = 1'b0;
        #1;
    endtask

    task automatic measure_period(input string req);
        int last_rise;
        int rise_cnt;
        int high_len;
        logic prev;
        last_rise = -1;
        rise_cnt = 0;
        high_len = -1;
        prev = clk_div;
        for (int t = 0; t < TOTAL * 4; t++) begin
            pulse(1'b1, 1'b0);
            if (!prev && clk_div) begin
                if (last_rise >= 0) begin
                    check({req, " period"}, t - last_rise, TOTAL);
                    rise_cnt++;
                end
                last_rise = t;
            end
            if (prev && !clk_div && last_rise >= 0) begin
                high_len = t - last_rise;
            end
            prev = clk_div;
        end
        check({req, " rises seen"}, (rise_cnt >= 2) ? 1 : 0, 1);
        check({req, " high time"}, high_len, TOTAL / 2);
    endtask

    task automatic shift_run(input logic [15:0] pat, input int len, input string req);
        logic low_val;
        for (int n = 0; n < 16 + len; n++) begin
            low_val = scan_out;
            if (n >= len) begin
                check(req, int'(low_val), int'(pat[n - len]));
            end
            scan_in = (n < 16) ? pat[n] : 1'b0;
            #HP;
            clk_fn = 1'b1;
            clk_scan = 1'b1;
            #1;
            check("R3 latch holds in high phase", int'(scan_out), int'(low_val));
            #(HP - 1);
            clk_fn = 1'b0;
            clk_scan = 1'b0;
            #1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        #3;
        check("R9 clk_div in reset", int'(clk_div), 0);
        check("R9 scan_out in reset", int'(scan_out), 0);
        rst_pin_n = 1'b1;
        #2;

        // R1: functional divide ratio
        measure_period("R1");
        // R8: fallback select ignored outside test mode
        hold_sel = 1'b1;
        measure_period("R8");
        hold_sel = 1'b0;

        // R7: scan clock ignored outside test mode
        for (int se = 0; se < 2; se++) begin
            logic div_ref;
            logic so_ref;
            scan_enable = logic'(se);
            div_ref = clk_div;
            so_ref = scan_out;
            for (int k = 0; k < 5; k++) pulse(1'b0, 1'b1);
            check("R7 clk_div unchanged", int'(clk_div), int'(div_ref));
            check("R7 scan_out unchanged", int'(scan_out), int'(so_ref));
        end

        // R2, R3: full chain shift through both sections
        scan_mode = 1'b1;
        scan_enable = 1'b1;
        for (int p = 0; p < NPAT; p++) begin
            shift_run(PATS[p], CHAIN_LEN, "R2 shift through full chain");
        end

        // R6: fallback bypasses and holds second section
        hold_sel = 1'b1;
        #1;
        shift_run(16'hC35A, HOLD_LEN, "R6 shortened chain");
        check("R6 clk_div held low after shift", int'(clk_div), 0);
        scan_enable = 1'b0;
        for (int k = 0; k < 4; k++) pulse(1'b0, 1'b1);
        check("R6 clk_div held low after capture pulses", int'(clk_div), 0);
        hold_sel = 1'b0;

        // R5: reset from pin in test mode, counting on scan clock alone
        #1;
        rst_pin_n = 1'b0;
        #2;
        check("R5 clk_div cleared by pin", int'(clk_div), 0);
        rst_pin_n = 1'b1;
        #2;
        for (int k = 0; k < (1 << (POST_BITS - 1)) - 1; k++) pulse(1'b0, 1'b1);
        check("R5 clk_div before top-bit count", int'(clk_div), 0);
        pulse(1'b0, 1'b1);
        check("R5 clk_div at top-bit count", int'(clk_div), 1);

        // R4: functional clock alone does not move second section in test mode
        for (int k = 0; k < 3 * TOTAL; k++) pulse(1'b1, 1'b0);
        check("R4 clk_div stays with functional pulses", int'(clk_div), 1);
        for (int k = 0; k < (1 << (POST_BITS - 1)); k++) pulse(1'b0, 1'b1);
        check("R4 clk_div wraps on scan pulses", int'(clk_div), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule